// File: doc/BRIEF.md
# Bridge Configuration Byte Space

This block holds the 256-byte configuration space of a PCI-to-PCI bridge function laid out as a type-1 header. A configuration agent issues single-byte requests that carry a function number, an 8-bit offset and, for writes, a data byte. Every offset has its own write behaviour. Some bytes are read-only. Some keep only the bits of a mask. Status bytes clear a bit wherever a 1 is written. All other bytes take the full value.

Reset loads the identity bytes from a parameter. It also loads the class code, the header type and the status reset values, and clears every other byte. A write to the secondary bus number produces a one-cycle event that the bus-numbering logic around the block can act on.

The block also routes interrupt requests from the downstream slots onto the four upstream lines. Each slot's pins are rotated by the slot number.

Top module: `bridge_cfg_space`

## Requirements
- R1: After reset every byte reads zero except these: offsets 0x00..0x03 hold ID_WORD bytes 0..3, least significant first; 0x0A reads 0x04; 0x0B reads 0x06; 0x0E reads 0x01; 0x07 reads STAT_HI_INIT (0x42); 0x1F reads SEC_STAT_HI_INIT (0xF2).
- R2: rvalid_o is high exactly one cycle after a cycle with rd_en_i high. rdata_o then carries the byte as it stood before any write issued in that same request cycle.
- R3: A request with func_i not zero reads 0xFF and leaves every byte unchanged.
- R4: Writes to offsets 0x00-0x03, 0x06, 0x08-0x0B, 0x0E, 0x0F, 0x10-0x17, 0x1E, 0x34 and 0x3D are discarded.
- R5: A write to offset 0x1C, 0x1D, 0x20, 0x22, 0x24 or 0x26 stores the data ANDed with 0xF0.
- R6: A write to offset 0x04 stores the data ANDed with CMD_LO_MASK (0x67). A write to 0x05 stores the data ANDed with CMD_HI_MASK (0x03).
- R7: A write to offset 0x3E stores the data ANDed with BCTL_LO_MASK (0xEF).
- R8: A write to 0x07 clears each stored bit where the data and STAT_HI_W1C (0x40) are both 1. A write to 0x1F does the same with SEC_STAT_HI_W1C (0xF0). No other bit changes.
- R9: A write to any other offset, including 0x18, 0x19, 0x3C and 0xFF, stores the full data byte.
- R10: A function-0 write to offset 0x19 raises bus_evt_o for exactly the next cycle, and sec_bus_o then shows the written value. Back-to-back writes give one high cycle per write, each showing its own value. Any other request leaves bus_evt_o low.
- R11: up_irq_o[l] is the OR of every dn_irq_i[s*4+p] with (s+p) mod 4 == l. Here s is the slot and p is the pin, with A=0, B=1, C=2, D=3. The path is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write request |
| rd_en_i | input | 1 | Byte read request |
| func_i | input | FUNC_W | Function number of the request |
| addr_i | input | 8 | Configuration offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| bus_evt_o | output | 1 | One-cycle secondary bus renumber event |
| sec_bus_o | output | 8 | Current secondary bus number |
| dn_irq_i | input | NUM_SLOTS*4 | Downstream requests, slot s pin p at bit s*4+p |
| up_irq_o | output | 4 | Upstream interrupt lines A..D |

## Verification
Most bytes can only be seen through reads. A wrong policy or wrong stored state therefore shows on rdata_o in the cycle after the next read of that offset. A full sweep of reads right after reset compares the whole image against the expected values. Corrupting the secondary bus byte shows at once on sec_bus_o, and a bad event pulse shows one cycle after the write. Interrupt routing faults appear in the same cycle as the stimulus, because the path holds no state.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;
  localparam int CFG_AW    = 8;
  localparam int CFG_BYTES = 1 << CFG_AW;
  localparam int IRQ_PINS  = 4;

  localparam logic [CFG_AW-1:0] OFF_STAT_HI     = 8'h07;
  localparam logic [CFG_AW-1:0] OFF_SEC_BUS     = 8'h19;
  localparam logic [CFG_AW-1:0] OFF_SEC_STAT_HI = 8'h1F;

  typedef enum logic [2:0] {
    POL_FULL,
    POL_RO,
    POL_NIBBLE,
    POL_CMD_LO,
    POL_CMD_HI,
    POL_BCTL,
    POL_W1C_STAT,
    POL_W1C_SEC
  } wpol_e;

  function automatic wpol_e offset_policy(input logic [CFG_AW-1:0] off);
    wpol_e p;
    case (off)
      8'h00, 8'h01, 8'h02, 8'h03, 8'h06,
      8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0E, 8'h0F,
      8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17,
      8'h1E, 8'h34, 8'h3D:                    p = POL_RO;
      8'h1C, 8'h1D, 8'h20, 8'h22, 8'h24, 8'h26: p = POL_NIBBLE;
      8'h04:                                  p = POL_CMD_LO;
      8'h05:                                  p = POL_CMD_HI;
      8'h3E:                                  p = POL_BCTL;
      OFF_STAT_HI:                            p = POL_W1C_STAT;
      OFF_SEC_STAT_HI:                        p = POL_W1C_SEC;
      default:                                p = POL_FULL;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/bcfg_wr_policy.sv
module bcfg_wr_policy
  import bcfg_pkg::*;
#(
  parameter logic [7:0] CMD_LO_MASK     = 8'h67,
  parameter logic [7:0] CMD_HI_MASK     = 8'h03,
  parameter logic [7:0] BCTL_LO_MASK    = 8'hEF,
  parameter logic [7:0] STAT_HI_W1C     = 8'h40,
  parameter logic [7:0] SEC_STAT_HI_W1C = 8'hF0
) (
  input  logic [CFG_AW-1:0] off_i,
  input  logic [7:0]        wdata_i,
  input  logic [7:0]        cur_i,
  output logic [7:0]        nxt_o,
  output logic              drop_o
);
  wpol_e pol;
  assign pol = offset_policy(off_i);

  always_comb begin
    drop_o = 1'b0;
    nxt_o  = wdata_i;
    case (pol)
      POL_RO:       drop_o = 1'b1;
      POL_NIBBLE:   nxt_o  = wdata_i & 8'hF0;
      POL_CMD_LO:   nxt_o  = wdata_i & CMD_LO_MASK;
      POL_CMD_HI:   nxt_o  = wdata_i & CMD_HI_MASK;
      POL_BCTL:     nxt_o  = wdata_i & BCTL_LO_MASK;
      // write-one-to-clear, limited to the clearable bits
      POL_W1C_STAT: nxt_o  = cur_i & ~(wdata_i & STAT_HI_W1C);
      POL_W1C_SEC:  nxt_o  = cur_i & ~(wdata_i & SEC_STAT_HI_W1C);
      default:      nxt_o  = wdata_i;
    endcase
  end
endmodule

// File: rtl/bcfg_store.sv
module bcfg_store
  import bcfg_pkg::*;
#(
  parameter logic [31:0] ID_WORD          = 32'h5A31_C0DE,
  parameter logic [7:0]  STAT_HI_INIT     = 8'h42,
  parameter logic [7:0]  SEC_STAT_HI_INIT = 8'hF2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rbyte_o,
  output logic [7:0]        sec_bus_o
);
  function automatic logic [7:0] init_byte(input int idx);
    case (idx)
      0:       return ID_WORD[7:0];
      1:       return ID_WORD[15:8];
      2:       return ID_WORD[23:16];
      3:       return ID_WORD[31:24];
      7:       return STAT_HI_INIT;
      'h0A:    return 8'h04;
      'h0B:    return 8'h06;
      'h0E:    return 8'h01;
      'h1F:    return SEC_STAT_HI_INIT;
      default: return 8'h00;
    endcase
  endfunction

  logic [CFG_BYTES*8-1:0] mem_flat;

  for (genvar i = 0; i < CFG_BYTES; i++) begin : g_byte
    localparam logic [CFG_AW-1:0] OFF = CFG_AW'(i);
    localparam logic [7:0]        RST = init_byte(i);
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    byte_q <= RST;
      else if (we_i && addr_i == OFF) byte_q <= wdata_i;
    end
    assign mem_flat[i*8 +: 8] = byte_q;
  end

  assign rbyte_o   = mem_flat[{addr_i, 3'b000} +: 8];
  assign sec_bus_o = mem_flat[{OFF_SEC_BUS, 3'b000} +: 8];
endmodule

// File: rtl/bcfg_irq_route.sv
module bcfg_irq_route
  import bcfg_pkg::*;
#(
  parameter int NUM_SLOTS = 9
) (
  input  logic [NUM_SLOTS*IRQ_PINS-1:0] dn_irq_i,
  output logic [IRQ_PINS-1:0]           up_irq_o
);
  localparam int NUM_REQ = NUM_SLOTS * IRQ_PINS;

  // slot s pin p lands on upstream line (s+p) mod 4
  always_comb begin
    up_irq_o = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      for (int p = 0; p < IRQ_PINS; p++) begin
        if (dn_irq_i[s*IRQ_PINS+p]) up_irq_o[(s+p) % IRQ_PINS] = 1'b1;
      end
    end
  end

  if (NUM_REQ < IRQ_PINS) begin : g_bad_cfg
    initial $error("NUM_SLOTS must be at least 1");
  end
endmodule

// File: rtl/bridge_cfg_space.sv
module bridge_cfg_space
  import bcfg_pkg::*;
#(
  parameter int          FUNC_W           = 3,
  parameter int          NUM_SLOTS        = 9,
  parameter logic [31:0] ID_WORD          = 32'h5A31_C0DE,
  parameter logic [7:0]  CMD_LO_MASK      = 8'h67,
  parameter logic [7:0]  CMD_HI_MASK      = 8'h03,
  parameter logic [7:0]  BCTL_LO_MASK     = 8'hEF,
  parameter logic [7:0]  STAT_HI_W1C      = 8'h40,
  parameter logic [7:0]  SEC_STAT_HI_W1C  = 8'hF0,
  parameter logic [7:0]  STAT_HI_INIT     = 8'h42,
  parameter logic [7:0]  SEC_STAT_HI_INIT = 8'hF2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic                          rd_en_i,
  input  logic [FUNC_W-1:0]             func_i,
  input  logic [7:0]                    addr_i,
  input  logic [7:0]                    wdata_i,
  output logic [7:0]                    rdata_o,
  output logic                          rvalid_o,
  output logic                          bus_evt_o,
  output logic [7:0]                    sec_bus_o,
  input  logic [NUM_SLOTS*IRQ_PINS-1:0] dn_irq_i,
  output logic [IRQ_PINS-1:0]           up_irq_o
);
  logic       fn0;
  logic       wr_hit;
  logic [7:0] cur_byte;
  logic [7:0] nxt_byte;
  logic       drop;

  assign fn0    = (func_i == '0);
  assign wr_hit = wr_en_i & fn0;

  bcfg_wr_policy #(
    .CMD_LO_MASK    (CMD_LO_MASK),
    .CMD_HI_MASK    (CMD_HI_MASK),
    .BCTL_LO_MASK   (BCTL_LO_MASK),
    .STAT_HI_W1C    (STAT_HI_W1C),
    .SEC_STAT_HI_W1C(SEC_STAT_HI_W1C)
  ) u_policy (
    .off_i  (addr_i),
    .wdata_i(wdata_i),
    .cur_i  (cur_byte),
    .nxt_o  (nxt_byte),
    .drop_o (drop)
  );

  bcfg_store #(
    .ID_WORD         (ID_WORD),
    .STAT_HI_INIT    (STAT_HI_INIT),
    .SEC_STAT_HI_INIT(SEC_STAT_HI_INIT)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_hit & ~drop),
    .addr_i   (addr_i),
    .wdata_i  (nxt_byte),
    .rbyte_o  (cur_byte),
    .sec_bus_o(sec_bus_o)
  );

  // read samples the pre-write byte at the request edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      rvalid_o  <= 1'b0;
      bus_evt_o <= 1'b0;
    end else begin
      rvalid_o  <= rd_en_i;
      bus_evt_o <= wr_hit && (addr_i == OFF_SEC_BUS);
      if (rd_en_i) rdata_o <= fn0 ? cur_byte : 8'hFF;
    end
  end

  bcfg_irq_route #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
    .dn_irq_i(dn_irq_i),
    .up_irq_o(up_irq_o)
  );
endmodule

// File: rtl/bcfg_checker.sv
module bcfg_checker #(
  parameter int FUNC_W    = 3,
  parameter int NUM_SLOTS = 9
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   wr_en_i,
  input logic                   rd_en_i,
  input logic [FUNC_W-1:0]      func_i,
  input logic [7:0]             addr_i,
  input logic [7:0]             wdata_i,
  input logic [7:0]             rdata_o,
  input logic                   rvalid_o,
  input logic                   bus_evt_o,
  input logic [7:0]             sec_bus_o,
  input logic [NUM_SLOTS*4-1:0] dn_irq_i,
  input logic [3:0]             up_irq_o
);
  logic bus_wr;
  assign bus_wr = wr_en_i && (func_i == '0) && (addr_i == 8'h19);

  assert_rvalid_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);
  assert_rvalid_clr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o);
  assert_other_func_ff_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && func_i != '0) |=> rdata_o == 8'hFF);
  assert_other_func_nowr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && func_i != '0) |=> $stable(sec_bus_o));
  assert_bus_evt_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr |=> (bus_evt_o && sec_bus_o == $past(wdata_i)));
  assert_bus_evt_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_wr |=> !bus_evt_o);
  assert_irq_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_irq_i == '0) |-> (up_irq_o == 4'b0000));
  assert_irq_slot0_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(dn_irq_i) && dn_irq_i[0] |-> (up_irq_o == 4'b0001));
endmodule

bind bridge_cfg_space bcfg_checker #(.FUNC_W(FUNC_W), .NUM_SLOTS(NUM_SLOTS)) u_chk (.*);

// File: tb/test_bridge_cfg_space.sv
module test_bridge_cfg_space;
  localparam int          CLK_P     = 10;
  localparam int          FUNC_W    = 3;
  localparam int          NUM_SLOTS = 9;
  localparam logic [31:0] ID_W      = 32'h5A31_C0DE;
  localparam logic [7:0]  M_CLO = 8'h67, M_CHI = 8'h03, M_BCTL = 8'hEF;
  localparam logic [7:0]  C_ST = 8'h40, C_SST = 8'hF0, I_ST = 8'h42, I_SST = 8'hF2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [FUNC_W-1:0] func = '0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata, sec_bus;
  logic rvalid, bus_evt;
  logic [NUM_SLOTS*4-1:0] dn_irq = '0;
  logic [3:0] up_irq;

  always #(CLK_P/2) clk = ~clk;

  bridge_cfg_space #(
    .FUNC_W(FUNC_W), .NUM_SLOTS(NUM_SLOTS), .ID_WORD(ID_W),
    .CMD_LO_MASK(M_CLO), .CMD_HI_MASK(M_CHI), .BCTL_LO_MASK(M_BCTL),
    .STAT_HI_W1C(C_ST), .SEC_STAT_HI_W1C(C_SST),
    .STAT_HI_INIT(I_ST), .SEC_STAT_HI_INIT(I_SST)
  ) i_bridge_cfg_space (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .func_i(func), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .rvalid_o(rvalid), .bus_evt_o(bus_evt), .sec_bus_o(sec_bus),
    .dn_irq_i(dn_irq), .up_irq_o(up_irq)
  );

  int n_run = 0, n_fail = 0;
  logic [7:0] ref_mem [256];
  logic [7:0] exp_rdata;
  logic exp_evt;
  logic [31:0] lfsr = 32'hACE1_2468;

  task automatic chk(string tag, int act, int exp, string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_init(int a);
    case (a)
      0: return ID_W[7:0];   1: return ID_W[15:8];
      2: return ID_W[23:16]; 3: return ID_W[31:24];
      7: return I_ST;  'h1F: return I_SST;
      'h0A: return 8'h04; 'h0B: return 8'h06; 'h0E: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  task automatic ref_write(int a, logic [7:0] d);
    if (a inside {[0:3], 6, [8:'h0B], 'h0E, 'h0F, [16:'h17], 'h1E, 'h34, 'h3D}) return; // R4
    if (a inside {'h1C, 'h1D, 'h20, 'h22, 'h24, 'h26}) ref_mem[a] = d & 8'hF0;       // R5
    else if (a == 4)     ref_mem[a] = d & M_CLO;                                      // R6
    else if (a == 5)     ref_mem[a] = d & M_CHI;
    else if (a == 'h3E)  ref_mem[a] = d & M_BCTL;                                     // R7
    else if (a == 7)     ref_mem[a] = ref_mem[a] & ~(d & C_ST);                       // R8
    else if (a == 'h1F)  ref_mem[a] = ref_mem[a] & ~(d & C_SST);
    else                 ref_mem[a] = d;                                              // R9
  endtask

  function automatic logic [3:0] exp_up(logic [NUM_SLOTS*4-1:0] dn);
    logic [3:0] r = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      for (int p = 0; p < 4; p++)
        if (dn[s*4+p]) r[(s+p)%4] = 1'b1;
    return r;
  endfunction

  // called at a negedge; compares all outputs just after the next posedge
  task automatic cyc(bit w, bit r, int f, int a, int d, string tag);
    wr_en = w; rd_en = r; func = FUNC_W'(f); addr = 8'(a); wdata = 8'(d);
    if (r) exp_rdata = (f != 0) ? 8'hFF : ref_mem[a];
    exp_evt = w && f == 0 && a == 'h19;
    if (w && f == 0) ref_write(a, 8'(d));
    @(posedge clk); #1;
    chk("R2", rvalid, r, "rvalid");
    if (r) chk(tag, rdata, exp_rdata, $sformatf("rdata@%0h", a));
    chk("R10", bus_evt, exp_evt, "bus_evt");
    chk("R10", sec_bus, ref_mem['h19], "sec_bus");
    chk("R11", up_irq, exp_up(dn_irq), "up_irq");
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic rd(int a, string tag);           cyc(0, 1, 0, a, 0, tag); endtask
  task automatic wrt(int a, int d, string tag);   cyc(1, 0, 0, a, d, tag); endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = ref_init(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: full image after reset
    for (int i = 0; i < 256; i++) rd(i, "R1");

    // R4: read-only bytes
    foreach (ref_mem[i]) if (i inside {[0:3], 6, [8:'h0B], 'h0E, 'h0F, [16:'h17], 'h1E, 'h34, 'h3D}) begin
      wrt(i, 'hFF, "R4"); rd(i, "R4");
    end

    // R3: other functions
    cyc(1, 0, 1, 'h40, 'hAA, "R3"); rd('h40, "R3");
    cyc(1, 0, 7, 'h19, 'h77, "R3");
    cyc(0, 1, 5, 'h00, 0, "R3");
    cyc(0, 1, 1, 'h0A, 0, "R3");

    // R5
    foreach (ref_mem[i]) if (i inside {'h1C, 'h1D, 'h20, 'h22, 'h24, 'h26}) begin
      wrt(i, 'h5A, "R5"); rd(i, "R5");
    end
    // R6, R7
    wrt(4, 'hFF, "R6"); rd(4, "R6");
    wrt(5, 'hFF, "R6"); rd(5, "R6");
    wrt('h3E, 'hFF, "R7"); rd('h3E, "R7");
    // R8: write-one-to-clear
    wrt(7, 'h00, "R8"); rd(7, "R8");
    wrt(7, 'hFF, "R8"); rd(7, "R8");
    wrt('h1F, 'h30, "R8"); rd('h1F, "R8");
    wrt('h1F, 'hFF, "R8"); rd('h1F, "R8");
    // R9
    wrt('h18, 'h3C, "R9"); rd('h18, "R9");
    wrt('h3C, 'hA5, "R9"); rd('h3C, "R9");
    wrt('hFF, 'h81, "R9"); rd('hFF, "R9");
    // R10: back-to-back renumbering
    wrt('h19, 'h11, "R10");
    wrt('h19, 'h22, "R10");
    rd('h19, "R10");
    // R2: read and write in one cycle return the old byte
    cyc(1, 1, 0, 'h40, 'h5C, "R2"); rd('h40, "R2");
    cyc(1, 1, 0, 7, 'hFF, "R2");

    // R11: each single request, then mixes
    for (int b = 0; b < NUM_SLOTS*4; b++) begin
      dn_irq = '0; dn_irq[b] = 1'b1; rd(0, "R11");
    end
    dn_irq = {NUM_SLOTS{4'b0001}}; rd(0, "R11");
    dn_irq = '1; rd(0, "R11");
    dn_irq = '0;

    // mixed traffic against the model
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      dn_irq = (NUM_SLOTS*4)'({lfsr, lfsr});
      cyc(lfsr[0], lfsr[1], (lfsr[7:4] < 12) ? 0 : int'(lfsr[18:16]),
          int'(lfsr[15:8]), int'(lfsr[31:24]), "R9");
    end
    dn_irq = '0;
    for (int i = 0; i < 256; i++) rd(i, "R9");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule